// File: doc/BRIEF.md
# Multi-plane page address sequencer

This block generates the block/page address stream for a streaming transfer that spreads consecutive page-sized chunks across the planes of a flash die. A transfer is described by a start block, a start page, a plane count and a total number of pages. The sequencer checks this description once, when it loads. It then presents one block/page pair per chunk on a valid/ready handshake.

Inside one plane group the page number stays fixed and the block number steps up by one per chunk. Once every plane of the group has been served, the page number steps up by one and the block number returns to the start block. The read and write directions use the same ordering, so one instance serves both. A description with a misaligned start block, a page count that does not fit the plane count, or an unsupported plane code is refused with a one-cycle error pulse, and no addresses are emitted for it.

Top module: `mp_addr_seq`

## Requirements
- R1: After a synchronous active-high reset, `addr_valid` is 0, `load_ready` is 1 and `load_err` is 0.
- R2: One cycle after a valid load is accepted (`load_valid` and `load_ready` both high at a clock edge), `addr_valid` is 1 and the first pair is presented: the start block and the start page.
- R3: After a handshake (`addr_valid` and `addr_ready` both high) on a chunk that is not the last one in its plane group, the next pair keeps the same page, and the block is one higher.
- R4: After a handshake on the last chunk of a plane group that is not the final chunk, the next pair has the page one higher and the block back at the start block.
- R5: While `addr_valid` is high and `addr_ready` is low, the presented pair and `addr_last` hold their values.
- R6: `addr_last` is high exactly on the final (count-th) pair. After that pair's handshake, `addr_valid` is 0 and `load_ready` is 1 on the next cycle.
- R7: A load whose start block is not aligned to the plane count is refused: `load_err` is 1 for the cycle after the load, and `addr_valid` stays 0. Alignment means that the low log2(planes) bits of the block are zero.
- R8: A load whose page count is zero, or is not a whole multiple of the plane count, is refused in the same way as in R7.
- R9: The plane code `load_planes` selects 1, 2 or 4 planes with the values 0, 1 and 2. The value 3 is refused in the same way as in R7.
- R10: A `load_valid` that arrives while a transfer is in progress is ignored. The address stream continues unchanged.
- R11: `load_err` lasts a single cycle and never rises for a valid load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Transfer description is offered |
| load_ready | output | 1 | Sequencer is idle and takes a description |
| load_block | input | BLK_W | Start block |
| load_page | input | PG_W | Start page |
| load_planes | input | 2 | Plane code: 0=1, 1=2, 2=4, 3=invalid |
| load_count | input | CNT_W | Total pages in the transfer |
| load_err | output | 1 | One-cycle pulse when a description is refused |
| addr_valid | output | 1 | An address pair is presented |
| addr_ready | input | 1 | Consumer takes the presented pair |
| addr_block | output | BLK_W | Block address of the current chunk |
| addr_page | output | PG_W | Page address of the current chunk |
| addr_last | output | 1 | Current pair is the final one of the transfer |

## Verification
The bench builds the sequencer with a 6-bit block, a 4-bit page and a 5-bit count. At these widths a sweep covers every plane code, every start block from 0 to 7 and every page count from 0 to 9. That reaches each alignment case and each multiple and non-multiple of 1, 2 and 4 planes, including the zero count. Stalls inserted on a fixed pattern exercise the hold rule. On alternate runs, loads are offered while a transfer is in progress.

// File: rtl/mpseq_pkg.sv
package mpseq_pkg;

    typedef enum logic [1:0] {
        PL_ONE  = 2'd0,
        PL_TWO  = 2'd1,
        PL_FOUR = 2'd2,
        PL_BAD  = 2'd3
    } plane_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Index of the last plane in a group: planes - 1.
    function automatic logic [1:0] plane_max(input plane_code_e code);
        case (code)
            PL_TWO:  plane_max = 2'd1;
            PL_FOUR: plane_max = 2'd3;
            default: plane_max = 2'd0;
        endcase
    endfunction

    // The low bits that must be zero for alignment and for count divisibility.
    function automatic logic [1:0] low_mask(input plane_code_e code);
        low_mask = plane_max(code);
    endfunction

endpackage

// File: rtl/mpseq_validate.sv
module mpseq_validate
    import mpseq_pkg::*;
#(
    parameter int BLK_W = 10,
    parameter int CNT_W = 8
) (
    input  logic [1:0]       code,
    input  logic [BLK_W-1:0] block,
    input  logic [CNT_W-1:0] count,
    output logic             ok
);
    plane_code_e pc;
    logic [1:0]  mask;
    logic        aligned;
    logic        whole;
    logic        code_ok;

    always_comb begin
        pc      = plane_code_e'(code);
        mask    = low_mask(pc);
        code_ok = (pc != PL_BAD);
        aligned = ((block[1:0] & mask) == 2'b00);
        whole   = ((count[1:0] & mask) == 2'b00) && (count != '0);
        ok      = code_ok && aligned && whole;
    end
endmodule

// File: rtl/mpseq_walker.sv
module mpseq_walker
    import mpseq_pkg::*;
#(
    parameter int BLK_W = 10,
    parameter int PG_W  = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BLK_W-1:0] start_block,
    input  logic [PG_W-1:0]  start_page,
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       code,
    input  logic             step,
    output logic             busy,
    output logic [BLK_W-1:0] blk,
    output logic [PG_W-1:0]  pg,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

    seq_state_e       state;
    logic [BLK_W-1:0] base_blk;
    logic [CNT_W-1:0] remain;
    logic [1:0]       idx;
    logic [1:0]       idx_max;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            base_blk <= '0;
            blk      <= '0;
            pg       <= '0;
            remain   <= '0;
            idx      <= '0;
            idx_max  <= '0;
        end else if (start) begin
            state    <= ST_RUN;
            base_blk <= start_block;
            blk      <= start_block;
            pg       <= start_page;
            remain   <= count;
            idx      <= '0;
            idx_max  <= plane_max(plane_code_e'(code));
        end else if (step) begin
            if (remain == ONE_LEFT) begin
                state <= ST_IDLE;
            end else begin
                remain <= remain - ONE_LEFT;
                if (idx == idx_max) begin
                    idx <= '0;
                    blk <= base_blk;
                    pg  <= pg + PG_W'(1);
                end else begin
                    idx <= idx + 2'd1;
                    blk <= blk + BLK_W'(1);
                end
            end
        end
    end

    assign busy = (state == ST_RUN);
    assign last = (remain == ONE_LEFT);
endmodule

// File: rtl/mp_addr_seq.sv
module mp_addr_seq
    import mpseq_pkg::*;
#(
    parameter int BLK_W = 10,
    parameter int PG_W  = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_valid,
    output logic             load_ready,
    input  logic [BLK_W-1:0] load_block,
    input  logic [PG_W-1:0]  load_page,
    input  logic [1:0]       load_planes,
    input  logic [CNT_W-1:0] load_count,
    output logic             load_err,
    output logic             addr_valid,
    input  logic             addr_ready,
    output logic [BLK_W-1:0] addr_block,
    output logic [PG_W-1:0]  addr_page,
    output logic             addr_last
);
    logic desc_ok;
    logic accept;
    logic busy;
    logic is_last;

    mpseq_validate #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_val (
        .code  (load_planes),
        .block (load_block),
        .count (load_count),
        .ok    (desc_ok)
    );

    assign load_ready = !busy;
    assign accept     = load_valid && load_ready;

    mpseq_walker #(.BLK_W(BLK_W), .PG_W(PG_W), .CNT_W(CNT_W)) u_walk (
        .clk         (clk),
        .rst         (rst),
        .start       (accept && desc_ok),
        .start_block (load_block),
        .start_page  (load_page),
        .count       (load_count),
        .code        (load_planes),
        .step        (addr_valid && addr_ready),
        .busy        (busy),
        .blk         (addr_block),
        .pg          (addr_page),
        .last        (is_last)
    );

    always_ff @(posedge clk) begin
        if (rst) load_err <= 1'b0;
        else     load_err <= accept && !desc_ok;
    end

    assign addr_valid = busy;
    assign addr_last  = busy && is_last;
endmodule

// File: rtl/mpseq_checker.sv
module mpseq_checker #(
    parameter int BLK_W = 10,
    parameter int PG_W  = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             load_ready,
    input logic             load_err,
    input logic             addr_valid,
    input logic             addr_ready,
    input logic [BLK_W-1:0] addr_block,
    input logic [PG_W-1:0]  addr_page,
    input logic             addr_last
);
    logic hs;
    assign hs = addr_valid && addr_ready;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        load_ready |-> !addr_valid);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_block)
            && $stable(addr_page) && $stable(addr_last)));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (hs && !addr_last) |=> (addr_valid &&
            ((addr_page == $past(addr_page) && addr_block == $past(addr_block) + BLK_W'(1))
             || (addr_page == $past(addr_page) + PG_W'(1)))));

    p_end_r6: assert property (@(posedge clk) disable iff (rst)
        (hs && addr_last) |=> (!addr_valid && load_ready));

    p_err_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        load_err |=> !load_err);

    p_err_no_addr_r7: assert property (@(posedge clk) disable iff (rst)
        load_err |-> !addr_valid);
endmodule

bind mp_addr_seq mpseq_checker #(.BLK_W(BLK_W), .PG_W(PG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_ready (load_ready),
    .load_err   (load_err),
    .addr_valid (addr_valid),
    .addr_ready (addr_ready),
    .addr_block (addr_block),
    .addr_page  (addr_page),
    .addr_last  (addr_last)
);

// File: tb/mp_addr_seq_test.sv
module mp_addr_seq_test;
    localparam int BLK_W = 6;
    localparam int PG_W  = 4;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst;
    logic             load_valid;
    logic             load_ready;
    logic [BLK_W-1:0] load_block;
    logic [PG_W-1:0]  load_page;
    logic [1:0]       load_planes;
    logic [CNT_W-1:0] load_count;
    logic             load_err;
    logic             addr_valid;
    logic             addr_ready;
    logic [BLK_W-1:0] addr_block;
    logic [PG_W-1:0]  addr_page;
    logic             addr_last;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    mp_addr_seq #(.BLK_W(BLK_W), .PG_W(PG_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .load_valid(load_valid), .load_ready(load_ready),
        .load_block(load_block), .load_page(load_page), .load_planes(load_planes),
        .load_count(load_count), .load_err(load_err), .addr_valid(addr_valid),
        .addr_ready(addr_ready), .addr_block(addr_block), .addr_page(addr_page),
        .addr_last(addr_last)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic run(input int code, input int blk, input int pg, input int cnt, input bit junk);
        int  planes;
        bit  good;
        int  eb;
        int  ep;
        planes = (code == 0) ? 1 : (code == 1) ? 2 : 4;
        good   = (code != 3) && (blk % planes == 0) && (cnt != 0) && (cnt % planes == 0);
        check("R1 idle before load", int'(load_ready), 1);
        load_valid  = 1'b1;
        load_block  = BLK_W'(blk);
        load_page   = PG_W'(pg);
        load_planes = 2'(code);
        load_count  = CNT_W'(cnt);
        tick();
        if (junk) begin
            load_block  = 6'd1;
            load_page   = 4'd9;
            load_planes = 2'd0;
            load_count  = 5'd2;
        end else begin
            load_valid = 1'b0;
        end
        if (!good) begin
            load_valid = 1'b0;
            if (code == 3)
                check("R9 bad plane code err", int'(load_err), 1);
            else if (blk % planes != 0)
                check("R7 misaligned err", int'(load_err), 1);
            else
                check("R8 count err", int'(load_err), 1);
            check("R7 no address on refusal", int'(addr_valid), 0);
            tick();
            check("R11 err single pulse", int'(load_err), 0);
            check("R7 still no address", int'(addr_valid), 0);
            return;
        end
        check("R11 no err on good load", int'(load_err), 0);
        for (int k = 0; k < cnt; k++) begin
            eb = blk + (k % planes);
            ep = pg + (k / planes);
            if (((k + blk) % 3) == 0) begin
                addr_ready = 1'b0;
                tick();
                check("R5 valid held", int'(addr_valid), 1);
                check("R5 block held", int'(addr_block), eb);
                check("R5 page held", int'(addr_page), ep);
            end
            addr_ready = 1'b1;
            check(k == 0 ? "R2 first valid" : "R10 valid", int'(addr_valid), 1);
            check((k % planes == 0) ? (k == 0 ? "R2 block" : "R4 block rewind") : "R3 block step",
                  int'(addr_block), eb);
            check((k % planes == 0) ? (k == 0 ? "R2 page" : "R4 page step") : "R3 page hold",
                  int'(addr_page), ep);
            check("R6 last flag", int'(addr_last), (k == cnt - 1) ? 1 : 0);
            tick();
        end
        addr_ready = 1'b0;
        load_valid = 1'b0;
        check("R6 valid drops", int'(addr_valid), 0);
        check("R6 ready returns", int'(load_ready), 1);
        check("R11 no err after junk", int'(load_err), 0);
    endtask

    initial begin
        rst         = 1'b1;
        load_valid  = 1'b0;
        load_block  = '0;
        load_page   = '0;
        load_planes = '0;
        load_count  = '0;
        addr_ready  = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset valid", int'(addr_valid), 0);
        check("R1 reset ready", int'(load_ready), 1);
        check("R1 reset err", int'(load_err), 0);
        for (int code = 0; code < 4; code++)
            for (int blk = 0; blk < 8; blk++)
                for (int cnt = 0; cnt < 10; cnt++)
                    run(code, blk, (blk % 4) + 1, cnt, ((blk + cnt) % 2) == 1);
        done = 1;
        finish_run();
    end
endmodule